// File: doc/BRIEF.md
# Centered Binomial Noise Sampler

This block converts a stream of pseudorandom bytes into a polynomial of 256 small signed coefficients. Each coefficient is drawn from a centered binomial distribution. The caller requests a job with a start pulse and a 2-bit distribution selector, which is captured when the job is accepted. The caller then streams bytes over a valid/ready input port. Coefficients leave over a valid/ready output port as 12-bit two's-complement values, and a last flag marks the final one.

The incoming bytes are read as one bit stream, least significant bit first, with byte 0 first. An internal bit buffer cuts this stream into 4-bit fields (narrow mode) or 6-bit fields (wide mode). A 6-bit field may span two bytes. For each field, the block counts the set bits in its lower half and in its upper half, and emits the lower count minus the upper count. The byte source, such as an extendable-output hash, sits outside the block. Modular reduction of the coefficients is also done outside.

Top module: `cbd_noise_sampler`

## Requirements
- R1: After a synchronous active-low reset, out_valid_o, out_last_o and in_ready_o are 0.
- R2: In narrow mode, coefficient i is taken from stream bits 4i..4i+3 (f0..f3) and equals (f0+f1)-(f2+f3).
- R3: When eta_i equals 3 at job start, the job runs in wide mode. Coefficient i is taken from stream bits 6i..6i+5 (f0..f5) and equals (f0+f1+f2)-(f3+f4+f5).
- R4: Any eta_i value other than 3 at job start (0, 1 or 2) selects narrow mode.
- R5: Stream bit k is bit (k mod 8) of the k/8-th accepted byte (integer division). A field that spans a byte boundary is assembled across both bytes.
- R6: Each job delivers exactly 256 coefficients. out_last_o is 1 together with the 256th coefficient and with no other.
- R7: A job accepts exactly 128 bytes in narrow mode and 192 in wide mode. After the last coefficient is transferred, in_ready_o stays 0 until the next start.
- R8: Coefficients are 12-bit two's complement within [-2,2] in narrow mode and [-3,3] in wide mode. For example, -2 is 0xFFE and -3 is 0xFFD.
- R9: While out_valid_o is 1 and out_ready_i is 0, out_valid_o stays 1 and out_coeff_o and out_last_o do not change on the next cycle.
- R10: A start pulse during a running job is ignored: the job's mode, buffered bits and coefficient sequence are unaffected.
- R11: The mode is latched at job start. Changes on eta_i during a job have no effect on it.
- R12: Reset asserted in the middle of a job returns the block to idle with no coefficient pending. The next job is then correct.
- R13: While idle, in_ready_o is 0 and offered bytes are not absorbed. The first byte after start becomes byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Job start request, accepted only in idle |
| eta_i | input | 2 | Distribution selector: 3 gives wide mode, any other value gives narrow mode |
| in_valid_i | input | 1 | Input byte valid |
| in_byte_i | input | 8 | Input byte |
| in_ready_o | output | 1 | Block can take a byte this cycle |
| out_valid_o | output | 1 | Coefficient valid |
| out_coeff_o | output | 12 | Signed coefficient, two's complement |
| out_last_o | output | 1 | Marks the 256th coefficient of the job |
| out_ready_i | input | 1 | Consumer accepts the coefficient |

## Verification
On every cycle, the assertions check the following. Each coefficient lies inside the range of the latched mode. A stalled output is held steady. The last flag appears only on a valid output. The byte input closes once the final coefficient is taken. The bit buffer never underflows or overflows. A start pulse while busy leaves the mode untouched. The scenarios alone show that the fields are cut in the correct bit order, including fields that span two bytes, that each job has the exact coefficient and byte counts, and that the block recovers from a reset in mid-job. The bench shows these by comparing every coefficient against a bit-level model of random and patterned byte streams, under random input gaps and output stalls.

// File: rtl/cbd_pkg.sv
package cbd_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } job_state_t;

   localparam int unsigned NARROW_W = 4;
   localparam int unsigned WIDE_W   = 6;
   localparam logic [1:0]  ETA_WIDE = 2'd3;
endpackage

// File: rtl/cbd_bitbuf.sv
module cbd_bitbuf #(
   parameter int unsigned BUF_W  = 16,
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              push_i,
   input  logic [BYTE_W-1:0] push_data_i,
   input  logic              pop_i,
   input  logic [CNT_W-1:0]  pop_w_i,
   output logic [BUF_W-1:0]  bits_o,
   output logic [CNT_W-1:0]  fill_o
);
   localparam logic [CNT_W-1:0] ROOM_LIM = CNT_W'(BUF_W - BYTE_W);
   localparam logic [CNT_W-1:0] PUSH_N   = CNT_W'(BYTE_W);

   logic [BUF_W-1:0] bits_q, bits_d, after_pop;
   logic [CNT_W-1:0] fill_q, fill_d, fill_mid;

   always_comb begin
      after_pop = pop_i ? (bits_q >> pop_w_i) : bits_q;
      fill_mid  = pop_i ? (fill_q - pop_w_i) : fill_q;
      bits_d    = after_pop;
      fill_d    = fill_mid;
      if (push_i) begin
         bits_d = after_pop | (BUF_W'(push_data_i) << fill_mid);
         fill_d = fill_mid + PUSH_N;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) begin
         bits_q <= '0;
         fill_q <= '0;
      end else begin
         bits_q <= bits_d;
         fill_q <= fill_d;
      end
   end

   assign bits_o = bits_q;
   assign fill_o = fill_q;

   // R5
   pop_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> (pop_w_i <= fill_q));

   // R7
   push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> (fill_q <= ROOM_LIM));
endmodule

// File: rtl/cbd_field_map.sv
module cbd_field_map
   import cbd_pkg::*;
#(
   parameter int unsigned COEF_W = 12
) (
   input  logic [WIDE_W-1:0] fld_i,
   input  logic              wide_i,
   output logic [COEF_W-1:0] coef_o
);
   logic [3:0] diff [2];
   logic [3:0] pick;

   for (genvar v = 0; v < 2; v++) begin : g_var
      localparam int HALF = (v == 0) ? int'(NARROW_W / 2) : int'(WIDE_W / 2);
      logic [2:0] pos_n, neg_n;
      always_comb begin
         pos_n = '0;
         neg_n = '0;
         for (int j = 0; j < HALF; j++) begin
            pos_n = pos_n + 3'(fld_i[j]);
            neg_n = neg_n + 3'(fld_i[HALF+j]);
         end
      end
      assign diff[v] = {1'b0, pos_n} - {1'b0, neg_n};
   end

   assign pick   = wide_i ? diff[1] : diff[0];
   assign coef_o = COEF_W'(signed'(pick));
endmodule

// File: rtl/cbd_noise_sampler.sv
module cbd_noise_sampler
   import cbd_pkg::*;
#(
   parameter int unsigned N_COEF = 256,
   parameter int unsigned COEF_W = 12,
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned BUF_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [1:0]        eta_i,
   input  logic              in_valid_i,
   input  logic [BYTE_W-1:0] in_byte_i,
   output logic              in_ready_o,
   output logic              out_valid_o,
   output logic [COEF_W-1:0] out_coeff_o,
   output logic              out_last_o,
   input  logic              out_ready_i
);
   localparam int unsigned CNT_W     = $clog2(BUF_W + 1);
   localparam int unsigned IDX_W     = $clog2(N_COEF + 1);
   localparam int unsigned NB_NARROW = N_COEF * NARROW_W / BYTE_W;
   localparam int unsigned NB_WIDE   = N_COEF * WIDE_W / BYTE_W;
   localparam int unsigned BC_W      = $clog2(NB_WIDE + 1);

   localparam logic [CNT_W-1:0] ROOM_LIM = CNT_W'(BUF_W - BYTE_W);
   localparam logic [CNT_W-1:0] FW_N     = CNT_W'(NARROW_W);
   localparam logic [CNT_W-1:0] FW_W     = CNT_W'(WIDE_W);
   localparam logic [IDX_W-1:0] IDX_END  = IDX_W'(N_COEF);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_COEF - 1);
   localparam logic [BC_W-1:0]  BC_NARROW = BC_W'(NB_NARROW);
   localparam logic [BC_W-1:0]  BC_WIDE   = BC_W'(NB_WIDE);

   if (BUF_W < WIDE_W + BYTE_W - 1) begin : g_bad_buf
      $error("cbd_noise_sampler: BUF_W too small for a straddling wide field");
   end
   if (COEF_W < 4) begin : g_bad_coef
      $error("cbd_noise_sampler: COEF_W must be at least 4");
   end
   if (((N_COEF * NARROW_W) % BYTE_W) != 0 || ((N_COEF * WIDE_W) % BYTE_W) != 0) begin : g_bad_cnt
      $error("cbd_noise_sampler: N_COEF fields must fill whole bytes");
   end

   job_state_t        state_q;
   logic              wide_q;
   logic [BC_W-1:0]   bytes_q;
   logic [IDX_W-1:0]  coef_q;
   logic [CNT_W-1:0]  fw, fill;
   logic [BC_W-1:0]   byte_total;
   logic [BUF_W-1:0]  buf_bits;
   logic [COEF_W-1:0] map_coef;
   logic              start_ok, push, pop, slot_free, take_last;
   logic              out_valid_q, out_last_q;
   logic [COEF_W-1:0] out_coeff_q;

   assign fw         = wide_q ? FW_W : FW_N;
   assign byte_total = wide_q ? BC_WIDE : BC_NARROW;
   assign start_ok   = (state_q == ST_IDLE) && start_i;
   assign in_ready_o = (state_q == ST_RUN) && (fill <= ROOM_LIM) && (bytes_q != byte_total);
   assign push       = in_valid_i && in_ready_o;
   assign slot_free  = !out_valid_q || out_ready_i;
   assign pop        = (state_q == ST_RUN) && (fill >= fw) && slot_free && (coef_q != IDX_END);
   assign take_last  = out_valid_q && out_ready_i && out_last_q;

   cbd_bitbuf #(.BUF_W(BUF_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_buf (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear_i     (start_ok),
      .push_i      (push),
      .push_data_i (in_byte_i),
      .pop_i       (pop),
      .pop_w_i     (fw),
      .bits_o      (buf_bits),
      .fill_o      (fill)
   );

   cbd_field_map #(.COEF_W(COEF_W)) u_map (
      .fld_i  (buf_bits[WIDE_W-1:0]),
      .wide_i (wide_q),
      .coef_o (map_coef)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         wide_q  <= 1'b0;
         bytes_q <= '0;
         coef_q  <= '0;
      end else begin
         if (start_ok) begin
            state_q <= ST_RUN;
            wide_q  <= (eta_i == ETA_WIDE);
            bytes_q <= '0;
            coef_q  <= '0;
         end else begin
            if (take_last) state_q <= ST_IDLE;
            if (push)      bytes_q <= bytes_q + 1'b1;
            if (pop)       coef_q  <= coef_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid_q <= 1'b0;
         out_last_q  <= 1'b0;
         out_coeff_q <= '0;
      end else if (pop) begin
         out_valid_q <= 1'b1;
         out_last_q  <= (coef_q == IDX_LAST);
         out_coeff_q <= map_coef;
      end else if (out_ready_i) begin
         out_valid_q <= 1'b0;
         out_last_q  <= 1'b0;
      end
   end

   assign out_valid_o = out_valid_q;
   assign out_last_o  = out_last_q;
   assign out_coeff_o = out_coeff_q;

   logic signed [COEF_W-1:0] lim_s;
   assign lim_s = wide_q ? COEF_W'(3) : COEF_W'(2);

   // R8
   coef_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o |-> (($signed(out_coeff_o) <= lim_s) && ($signed(out_coeff_o) >= -lim_s)));

   // R9
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_coeff_o) && $stable(out_last_o)));

   // R6
   last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_last_o |-> out_valid_o);

   // R7
   closed_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && out_ready_i && out_last_o) |=> !in_ready_o);

   // R10
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_RUN) && start_i) |=> $stable(wide_q));
endmodule

// File: tb/sim_cbd_noise_sampler.sv
module sim_cbd_noise_sampler;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        start_i;
   logic [1:0]  eta_i;
   logic        in_valid_i;
   logic [7:0]  in_byte_i;
   logic        in_ready_o;
   logic        out_valid_o;
   logic [11:0] out_coeff_o;
   logic        out_last_o;
   logic        out_ready_i;

   always #2 clk = ~clk;

   cbd_noise_sampler u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .eta_i(eta_i),
      .in_valid_i(in_valid_i), .in_byte_i(in_byte_i), .in_ready_o(in_ready_o),
      .out_valid_o(out_valid_o), .out_coeff_o(out_coeff_o), .out_last_o(out_last_o),
      .out_ready_i(out_ready_i)
   );

   int n_chk = 0;
   int n_err = 0;
   logic [7:0] stim [0:191];

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic bit sbit(input int k);
      return stim[k/8][k%8];
   endfunction

   function automatic logic [11:0] model(input int idx, input int fw);
      int pos = 0;
      int neg = 0;
      for (int j = 0; j < fw/2; j++) begin
         pos += int'(sbit(fw*idx + j));
         neg += int'(sbit(fw*idx + fw/2 + j));
      end
      return 12'(pos - neg);
   endfunction

   // pat: 0 random, 1 all 0xCC, 2 all 0x33, 3 wide -3 pattern, 4 all 0xFF
   task automatic fill_stim(input int pat);
      for (int b = 0; b < 192; b++) begin
         case (pat)
            1: stim[b] = 8'hCC;
            2: stim[b] = 8'h33;
            3: for (int t = 0; t < 8; t++) stim[b][t] = (((b*8+t) % 6) >= 3);
            4: stim[b] = 8'hFF;
            default: stim[b] = 8'($urandom);
         endcase
      end
   endtask

   task automatic run_job(input int eta_sel, input int pat, input int gap_pct,
                          input int stall_pct, input bit disturb, input int fixed_exp,
                          input string tag);
      int fw = (eta_sel == 3) ? 6 : 4;
      int nbytes = fw * 32;
      int bi = 0;
      int got = 0;
      int lasts = 0;
      bit hold = 0;
      logic [11:0] hold_val = '0;
      bit rdy, vld;
      fill_stim(pat);
      @(negedge clk);
      eta_i = 2'(eta_sel);
      start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      // R11: selector flipped after start must not matter
      if (disturb) eta_i = (eta_sel == 3) ? 2'd2 : 2'd3;
      while (got < 256) begin
         if (hold)  // R9
            check(out_valid_o && out_coeff_o == hold_val, "R9 held output", int'(out_coeff_o), int'(hold_val));
         rdy = (($urandom % 100) >= stall_pct);
         vld = (($urandom % 100) >= gap_pct);
         out_ready_i = rdy;
         in_valid_i  = vld;
         in_byte_i   = (bi < 192) ? stim[bi] : 8'hA5;
         if (vld && in_ready_o) bi++;
         hold = out_valid_o && !rdy;
         hold_val = out_coeff_o;
         if (out_valid_o && rdy) begin
            check(out_coeff_o == model(got, fw), tag, int'(out_coeff_o), int'(model(got, fw)));
            if (fixed_exp >= 0)  // R8
               check(out_coeff_o == 12'(fixed_exp), "R8 fixed code", int'(out_coeff_o), fixed_exp);
            if (out_last_o) lasts++;
            if (got == 255)  // R6
               check(out_last_o == 1'b1, "R6 last on 256th", int'(out_last_o), 1);
            got++;
         end
         // R10: start pulses while busy, with the other selector value
         start_i = disturb && (got % 37 == 5);
         if (disturb && start_i) eta_i = (eta_sel == 3) ? 2'd2 : 2'd3;
         @(posedge clk);
         @(negedge clk);
      end
      start_i = 1'b0;
      in_valid_i = 1'b1;
      out_ready_i = 1'b1;
      check(lasts == 1, "R6 single last", lasts, 1);
      check(bi == nbytes, "R7 bytes consumed", bi, nbytes);
      for (int c = 0; c < 4; c++) begin
         check(!in_ready_o && !out_valid_o, "R7 closed after job", int'({in_ready_o, out_valid_o}), 0);
         @(posedge clk);
         @(negedge clk);
      end
      in_valid_i = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL R6 watchdog act=hung exp=done");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd7321));
      rst_n = 1'b0; start_i = 1'b0; eta_i = 2'd2;
      in_valid_i = 1'b0; in_byte_i = '0; out_ready_i = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1
      check(!out_valid_o && !out_last_o && !in_ready_o, "R1 reset state",
            int'({out_valid_o, out_last_o, in_ready_o}), 0);
      // R13: bytes offered while idle
      in_valid_i = 1'b1;
      in_byte_i  = 8'h5A;
      for (int c = 0; c < 5; c++) begin
         check(!in_ready_o, "R13 idle ready", int'(in_ready_o), 0);
         @(posedge clk);
         @(negedge clk);
      end
      in_valid_i = 1'b0;
      run_job(2, 0, 0, 0, 0, -1, "R13 R2 R5 first after idle");
      run_job(3, 0, 30, 30, 0, -1, "R3 R5 wide random");
      run_job(2, 1, 10, 40, 0, 12'hFFE, "R2 all 0xCC");
      run_job(3, 3, 0, 20, 0, 12'hFFD, "R3 R5 straddle -3");
      run_job(2, 2, 20, 0, 0, 12'h002, "R2 all 0x33");
      run_job(3, 4, 0, 0, 0, 12'h000, "R3 all ones");
      run_job(0, 0, 25, 25, 0, -1, "R4 eta 0");
      run_job(1, 0, 25, 25, 0, -1, "R4 eta 1");
      run_job(3, 0, 10, 75, 0, -1, "R9 R3 heavy stall");
      run_job(2, 0, 20, 20, 1, -1, "R10 R11 narrow disturbed");
      run_job(3, 0, 20, 20, 1, -1, "R10 R11 wide disturbed");
      // R12: reset in the middle of a job
      fill_stim(0);
      @(negedge clk);
      eta_i = 2'd3; start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0; in_valid_i = 1'b1; out_ready_i = 1'b0;
      for (int c = 0; c < 20; c++) begin
         in_byte_i = 8'($urandom);
         @(posedge clk);
         @(negedge clk);
      end
      in_valid_i = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check(!out_valid_o && !in_ready_o, "R12 mid-job reset", int'({out_valid_o, in_ready_o}), 0);
      run_job(3, 0, 15, 15, 0, -1, "R12 R3 job after reset");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule